// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block watches the register numbers and control flags of a five-stage in-order pipeline (Fetch, Decode, Execute, Memory, Writeback). From them it works out, in the same cycle and without any storage, how each Execute-stage ALU operand and each Decode-stage branch-comparator operand should be steered, and when the front of the pipeline must be frozen or a stage must be emptied. The datapath, pipeline registers, ALU and memories sit outside. They read the selects, hold-enables and clear signals that this block drives.

Branches are resolved in Decode, so a taken branch costs one discarded instruction. The cost of this is that the Decode comparator needs its own forwarding path from the Memory stage. A branch whose operands are still being produced by an instruction further down the pipeline must wait. A load whose data is wanted by the very next instruction also forces a one-cycle bubble. A freeze always beats the taken-branch flush, so a waiting branch never redirects fetch on stale operands.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: Each Execute operand select is 2'b10 (Memory-stage ALU result) when its source matches the Memory destination and the Memory stage writes a register. Otherwise it is 2'b01 (Writeback result) when the source matches the Writeback destination and Writeback writes a register. Otherwise it is 2'b00 (register file). Memory wins when both stages match.
- R2: A source of register 0, or a match against a stage whose write flag is clear, never produces a forward in either the Execute or the Decode select. The select stays 0 and the register-file value is used.
- R3: Each Decode comparator select is 1 exactly when its Decode source is non-zero, equals the Memory destination, and the Memory stage writes a register. Otherwise it is 0.
- R4: A load in Execute (load flag set) whose destination equals either Decode source raises a stall.
- R5: A branch in Decode stalls when the Execute instruction writes a register whose number equals either branch source. This holds for an ALU instruction in Execute that is not a load.
- R6: A branch in Decode stalls when a load in Memory targets either branch source. A branch behind a load therefore waits two cycles in total.
- R7: The Fetch hold, the Decode hold and the Execute clear are always driven to the same value, which is 1 exactly during a stall.
- R8: The Decode clear is 1 when Decode holds a branch whose comparator reports equality and no stall is raised. A stall in the same cycle suppresses it.
- R9: Without a load in Execute and without a branch in Decode, register matches never stall. They are fully covered by forwarding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_src_a | input | REG_AW | First source register number in Decode |
| dec_src_b | input | REG_AW | Second source register number in Decode |
| exe_src_a | input | REG_AW | First source register number in Execute |
| exe_src_b | input | REG_AW | Second source register number in Execute |
| exe_dst | input | REG_AW | Destination register number in Execute |
| mem_dst | input | REG_AW | Destination register number in Memory |
| wb_dst | input | REG_AW | Destination register number in Writeback |
| exe_wr | input | 1 | Execute instruction writes a register |
| mem_wr | input | 1 | Memory instruction writes a register |
| wb_wr | input | 1 | Writeback instruction writes a register |
| exe_load | input | 1 | Execute instruction takes its result from memory |
| mem_load | input | 1 | Memory instruction takes its result from memory |
| dec_branch | input | 1 | Decode holds a conditional branch |
| dec_equal | input | 1 | Decode comparator reports equal operands |
| exe_fwd_a | output | 2 | Execute first-operand select |
| exe_fwd_b | output | 2 | Execute second-operand select |
| dec_fwd_a | output | 1 | Decode comparator first-operand select |
| dec_fwd_b | output | 1 | Decode comparator second-operand select |
| hold_fetch | output | 1 | Keep the Fetch register (PC) unchanged |
| hold_decode | output | 1 | Keep the Decode register unchanged |
| kill_decode | output | 1 | Clear the Decode register |
| kill_execute | output | 1 | Clear the Execute register (bubble) |

## Verification
The taken-branch flush and the stall can both be requested in one cycle: a branch with equal operands sits in Decode while a load in Execute or Memory, or an ALU writer in Execute, targets one of its sources. The bench builds such vectors on purpose and also meets them often in a sweep over a narrow set of register numbers (0 to 3), where collisions are dense. It judges them by requiring the hold and Execute-clear outputs high and the Decode clear low. Forwarding selects and a load-use stall likewise coincide. The bench checks that both are driven at once and that neither disturbs the other.

// File: rtl/hz_pkg.sv
// Shared types for the pipeline hazard controller.
// Assumes: a two-bit code for the Execute operand source.
package hz_pkg;

    localparam int unsigned EXE_FWD_W = 2;

    // Execute operand source codes; the datapath mux decodes these values.
    typedef enum logic [EXE_FWD_W-1:0] {
        FWD_REGFILE = 2'b00,
        FWD_WRITEBK = 2'b01,
        FWD_MEMSTG  = 2'b10
    } exe_fwd_e;

endpackage

// File: rtl/hz_exe_fwd.sv
// Execute-stage operand steering for a single ALU source.
// Picks the Memory-stage ALU value over the Writeback value when both match,
// and never forwards for register 0 or from a stage that does not write.
module hz_exe_fwd
    import hz_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wr,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_wr,
    output exe_fwd_e          sel
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic live_src;
    logic hit_mem;
    logic hit_wb;

    // Qualify each candidate producer against this source.
    always_comb begin
        live_src = (src != ZERO_REG);
        hit_mem  = live_src && mem_wr && (src == mem_dst);
        hit_wb   = live_src && wb_wr && (src == wb_dst);
    end

    // Youngest producer wins.
    always_comb begin
        if (hit_mem)
            sel = FWD_MEMSTG;
        else if (hit_wb)
            sel = FWD_WRITEBK;
        else
            sel = FWD_REGFILE;
    end

endmodule

// File: rtl/hz_dec_fwd.sv
// Decode-stage comparator steering for a single branch source.
// Only the Memory-stage ALU value is a candidate: Writeback results reach
// the register file read in the same cycle because writes land first.
module hz_dec_fwd #(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wr,
    output logic              sel
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // Forward when the Memory stage will write this non-zero source.
    always_comb begin
        sel = (src != ZERO_REG) && mem_wr && (src == mem_dst);
    end

endmodule

// File: rtl/hz_stall.sv
// Stall and flush decision for the pipeline front end.
// Raises a stall for load-use and for branch operands still in flight;
// the stall freezes Fetch and Decode and bubbles Execute. A taken branch
// clears Decode only when no stall is raised in the same cycle.
module hz_stall #(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] dec_src_a,
    input  logic [REG_AW-1:0] dec_src_b,
    input  logic [REG_AW-1:0] exe_dst,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              exe_wr,
    input  logic              exe_load,
    input  logic              mem_load,
    input  logic              dec_branch,
    input  logic              dec_equal,
    output logic              stall,
    output logic              flush_dec
);

    logic exe_hits_dec;
    logic mem_hits_dec;
    logic load_use;
    logic branch_wait;

    // Compare downstream destinations with both Decode sources.
    always_comb begin
        exe_hits_dec = (exe_dst == dec_src_a) || (exe_dst == dec_src_b);
        mem_hits_dec = (mem_dst == dec_src_a) || (mem_dst == dec_src_b);
    end

    // Load data is late: the next consumer must wait one cycle.
    always_comb begin
        load_use = exe_load && exe_hits_dec;
    end

    // Early branch compare needs operands not still in Execute or in a load.
    always_comb begin
        branch_wait = dec_branch &&
                      ((exe_wr && exe_hits_dec) || (mem_load && mem_hits_dec));
    end

    // Stall has priority over the taken-branch clear.
    always_comb begin
        stall     = load_use || branch_wait;
        flush_dec = dec_branch && dec_equal && !stall;
    end

endmodule

// File: rtl/pipe_hazard_ctl.sv
// Hazard controller for a five-stage in-order pipeline with branches
// resolved in Decode. Purely combinational: all outputs follow the current
// stage contents. Assumes the register file writes before it reads.
module pipe_hazard_ctl
    import hz_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] dec_src_a,
    input  logic [REG_AW-1:0] dec_src_b,
    input  logic [REG_AW-1:0] exe_src_a,
    input  logic [REG_AW-1:0] exe_src_b,
    input  logic [REG_AW-1:0] exe_dst,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              exe_wr,
    input  logic              mem_wr,
    input  logic              wb_wr,
    input  logic              exe_load,
    input  logic              mem_load,
    input  logic              dec_branch,
    input  logic              dec_equal,
    output logic [1:0]        exe_fwd_a,
    output logic [1:0]        exe_fwd_b,
    output logic              dec_fwd_a,
    output logic              dec_fwd_b,
    output logic              hold_fetch,
    output logic              hold_decode,
    output logic              kill_decode,
    output logic              kill_execute
);

    localparam int unsigned N_OPND = 2;

    logic [REG_AW-1:0] exe_src [N_OPND];
    logic [REG_AW-1:0] dec_src [N_OPND];
    exe_fwd_e          exe_sel [N_OPND];
    logic              dec_sel [N_OPND];
    logic              stall;
    logic              flush_dec;

    // Gather operands into arrays for the per-operand instances.
    always_comb begin
        exe_src[0] = exe_src_a;
        exe_src[1] = exe_src_b;
        dec_src[0] = dec_src_a;
        dec_src[1] = dec_src_b;
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        hz_exe_fwd #(.REG_AW(REG_AW)) u_exe_fwd (
            .src     (exe_src[g]),
            .mem_dst (mem_dst),
            .mem_wr  (mem_wr),
            .wb_dst  (wb_dst),
            .wb_wr   (wb_wr),
            .sel     (exe_sel[g])
        );

        hz_dec_fwd #(.REG_AW(REG_AW)) u_dec_fwd (
            .src     (dec_src[g]),
            .mem_dst (mem_dst),
            .mem_wr  (mem_wr),
            .sel     (dec_sel[g])
        );
    end

    hz_stall #(.REG_AW(REG_AW)) u_stall (
        .dec_src_a  (dec_src_a),
        .dec_src_b  (dec_src_b),
        .exe_dst    (exe_dst),
        .mem_dst    (mem_dst),
        .exe_wr     (exe_wr),
        .exe_load   (exe_load),
        .mem_load   (mem_load),
        .dec_branch (dec_branch),
        .dec_equal  (dec_equal),
        .stall      (stall),
        .flush_dec  (flush_dec)
    );

    // Drive the stage controls and selects.
    always_comb begin
        exe_fwd_a    = exe_sel[0];
        exe_fwd_b    = exe_sel[1];
        dec_fwd_a    = dec_sel[0];
        dec_fwd_b    = dec_sel[1];
        hold_fetch   = stall;
        hold_decode  = stall;
        kill_execute = stall;
        kill_decode  = flush_dec;
    end

endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
// Property checker for the hazard controller, bound to every instance.
// The block has no clock, so the checks are immediate and re-evaluated
// whenever an input or output moves.
module pipe_hazard_ctl_chk #(
    parameter int unsigned REG_AW = 5
) (
    input logic [REG_AW-1:0] dec_src_a,
    input logic [REG_AW-1:0] dec_src_b,
    input logic [REG_AW-1:0] exe_src_a,
    input logic [REG_AW-1:0] exe_dst,
    input logic [REG_AW-1:0] mem_dst,
    input logic              mem_wr,
    input logic              exe_load,
    input logic              dec_branch,
    input logic [1:0]        exe_fwd_a,
    input logic [1:0]        exe_fwd_b,
    input logic              dec_fwd_a,
    input logic              hold_fetch,
    input logic              hold_decode,
    input logic              kill_decode,
    input logic              kill_execute
);

    // Check the output relations against the stage inputs.
    always_comb begin
        // R1
        fwd_code_legal_chk: assert (exe_fwd_a != 2'b11 && exe_fwd_b != 2'b11);
        // R2
        no_zero_fwd_chk: assert (exe_src_a != '0 || exe_fwd_a == 2'b00);
        // R3
        dec_fwd_source_chk: assert (!dec_fwd_a || (mem_wr && dec_src_a == mem_dst));
        // R4
        load_use_hold_chk: assert (!(exe_load && (exe_dst == dec_src_a || exe_dst == dec_src_b))
                                   || hold_fetch);
        // R7
        stall_tied_chk: assert (hold_fetch == hold_decode && hold_decode == kill_execute);
        // R8
        flush_yields_chk: assert (!(kill_decode && hold_decode));
        // R8
        flush_needs_branch_chk: assert (!kill_decode || dec_branch);
    end

endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.REG_AW(REG_AW)) u_pipe_hazard_ctl_chk (
    .dec_src_a    (dec_src_a),
    .dec_src_b    (dec_src_b),
    .exe_src_a    (exe_src_a),
    .exe_dst      (exe_dst),
    .mem_dst      (mem_dst),
    .mem_wr       (mem_wr),
    .exe_load     (exe_load),
    .dec_branch   (dec_branch),
    .exe_fwd_a    (exe_fwd_a),
    .exe_fwd_b    (exe_fwd_b),
    .dec_fwd_a    (dec_fwd_a),
    .hold_fetch   (hold_fetch),
    .hold_decode  (hold_decode),
    .kill_decode  (kill_decode),
    .kill_execute (kill_execute)
);

// File: tb/test_pipe_hazard_ctl.sv
`timescale 1ns/1ps
// Bench: directed corner vectors, then a dense sweep over register numbers
// 0..3 with every flag free; expected outputs computed from the requirements.
module test_pipe_hazard_ctl;

    localparam int unsigned AW = 5;
    localparam int unsigned SWEEP = 6000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [AW-1:0] dsa, dsb, esa, esb, ed, md, wd;
    logic ew, mw, ww, el, ml, br, eq;
    logic [1:0] fa, fb;
    logic da, db, hf, hd, kd, ke;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    pipe_hazard_ctl #(.REG_AW(AW)) i_pipe_hazard_ctl (
        .dec_src_a (dsa), .dec_src_b (dsb),
        .exe_src_a (esa), .exe_src_b (esb),
        .exe_dst (ed), .mem_dst (md), .wb_dst (wd),
        .exe_wr (ew), .mem_wr (mw), .wb_wr (ww),
        .exe_load (el), .mem_load (ml),
        .dec_branch (br), .dec_equal (eq),
        .exe_fwd_a (fa), .exe_fwd_b (fb),
        .dec_fwd_a (da), .dec_fwd_b (db),
        .hold_fetch (hf), .hold_decode (hd),
        .kill_decode (kd), .kill_execute (ke)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int m_exe(input int s);
        if (s != 0 && mw && s == int'(md)) return 2;
        if (s != 0 && ww && s == int'(wd)) return 1;
        return 0;
    endfunction

    function automatic int m_dec(input int s);
        return (s != 0 && mw && s == int'(md)) ? 1 : 0;
    endfunction

    function automatic int m_stall();
        bit eh, mh, lu, bw;
        eh = (ed == dsa) || (ed == dsb);
        mh = (md == dsa) || (md == dsb);
        lu = el && eh;
        bw = br && ((ew && eh) || (ml && mh));
        return (lu || bw) ? 1 : 0;
    endfunction

    // Compare every output against the model.
    task automatic check_all(input string tag);
        int st;
        st = m_stall();
        chk({tag, " R1"}, "exe_fwd_a", int'(fa), m_exe(int'(esa)));
        chk({tag, " R1"}, "exe_fwd_b", int'(fb), m_exe(int'(esb)));
        chk({tag, " R3"}, "dec_fwd_a", int'(da), m_dec(int'(dsa)));
        chk({tag, " R3"}, "dec_fwd_b", int'(db), m_dec(int'(dsb)));
        chk({tag, " R4"}, "hold_fetch", int'(hf), st);
        chk({tag, " R7"}, "hold_decode", int'(hd), st);
        chk({tag, " R7"}, "kill_execute", int'(ke), st);
        chk({tag, " R8"}, "kill_decode", int'(kd), (br && eq && st == 0) ? 1 : 0);
    endtask

    task automatic idle();
        dsa = '0; dsb = '0; esa = '0; esb = '0; ed = '0; md = '0; wd = '0;
        ew = 0; mw = 0; ww = 0; el = 0; ml = 0; br = 0; eq = 0;
    endtask

    initial begin
        idle();
        @(negedge clk);
        // Quiet pipeline: everything low.
        chk("R2", "idle fa", int'(fa), 0);
        chk("R7", "idle hold", int'(hf), 0);
        chk("R8", "idle kill_decode", int'(kd), 0);

        // R1: both stages match; Memory must win.
        @(posedge clk); idle();
        esa = 5'd7; esb = 5'd9; md = 5'd7; mw = 1; wd = 5'd7; ww = 1;
        @(negedge clk);
        chk("R1", "mem priority", int'(fa), 2);
        chk("R1", "no match", int'(fb), 0);
        check_all("dir1");

        // R1: Writeback only.
        @(posedge clk); idle();
        esb = 5'd3; wd = 5'd3; ww = 1;
        @(negedge clk);
        chk("R1", "wb fwd", int'(fb), 1);

        // R2: register 0 never forwarded; write flag clear blocks a match.
        @(posedge clk); idle();
        md = '0; mw = 1; wd = '0; ww = 1; esb = 5'd4; wd = 5'd4; ww = 0;
        @(negedge clk);
        chk("R2", "zero src exe", int'(fa), 0);
        chk("R2", "zero src dec", int'(da), 0);
        chk("R2", "wr flag off", int'(fb), 0);

        // R4 with R1 together: load-use while Execute forwards.
        @(posedge clk); idle();
        el = 1; ew = 1; ed = 5'd8; dsb = 5'd8; esa = 5'd2; md = 5'd2; mw = 1;
        @(negedge clk);
        chk("R4", "load-use hold", int'(hf), 1);
        chk("R1", "fwd during stall", int'(fa), 2);

        // R5: ALU writer in Execute, branch in Decode, taken: stall wins (R8).
        @(posedge clk); idle();
        br = 1; eq = 1; ew = 1; ed = 5'd6; dsa = 5'd6;
        @(negedge clk);
        chk("R5", "branch alu wait", int'(hd), 1);
        chk("R8", "flush suppressed", int'(kd), 0);

        // R6: load in Memory feeding branch.
        @(posedge clk); idle();
        br = 1; eq = 1; ml = 1; mw = 1; md = 5'd11; dsb = 5'd11;
        @(negedge clk);
        chk("R6", "branch load wait", int'(ke), 1);
        chk("R6", "flush suppressed", int'(kd), 0);

        // R8: operands ready, taken branch flushes Decode only.
        @(posedge clk); idle();
        br = 1; eq = 1; dsa = 5'd1; dsb = 5'd2; md = 5'd1; mw = 1;
        @(negedge clk);
        chk("R8", "taken flush", int'(kd), 1);
        chk("R3", "dec fwd", int'(da), 1);
        chk("R7", "no bubble", int'(ke), 0);

        // R9: ALU writer in Execute without branch does not stall.
        @(posedge clk); idle();
        ew = 1; ed = 5'd5; dsa = 5'd5; ml = 1; md = 5'd5;
        @(negedge clk);
        chk("R9", "no stall", int'(hf), 0);

        // Dense sweep: register numbers 0..3 so collisions are frequent.
        for (int n = 0; n < SWEEP; n++) begin
            @(posedge clk);
            dsa = AW'($urandom_range(3)); dsb = AW'($urandom_range(3));
            esa = AW'($urandom_range(3)); esb = AW'($urandom_range(3));
            ed  = AW'($urandom_range(3)); md  = AW'($urandom_range(3));
            wd  = AW'($urandom_range(3));
            {ew, mw, ww, el, ml, br, eq} = 7'($urandom_range(127));
            @(negedge clk);
            check_all("sweep");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule